// File: doc/BRIEF.md
# Dual-Rail Precharged Byte Substitution Core

This block models one protected byte-wide cipher step. Each step produces one byte. An internal linear-feedback generator supplies the plaintext byte, the block XORs it with a key byte, and it passes the result through the AES substitution box, which is computed with combinational logic rather than read from a memory. The logic exists twice: a true rail carries the data and a false rail carries its complement. Each rail has its own key-mixing gates and its own substitution logic. At the end of every step, two capture registers hold the true and false results.

Two global strobes, a leading one and a lagging one, come from a shared Johnson counter. Every gate takes them as extra inputs. A gate leaves its precharged value, zero on both rails, only while both strobes are high. This makes each rail pair switch once into a valid one-hot code and once back to zero in every step. Precharge reaches all gates in the same clock rather than rippling through the logic. The source registers present their data only inside the window. The capture registers take the result in the window's last cycle and hold it through the next step.

Top module: `drp_byte_core`

## Requirements
- R1: While reset is high, and on the first cycle after it, ct_t_o, ct_f_o, pt_o, done_o and eval_o are all zero.
- R2: With default parameters, lead_o is high for 6 of every 12 clocks. lag_o is lead_o delayed by one clock. eval_o is high exactly when both are high, which is 5 of every 12 clocks.
- R3: Every internal true/false rail pair is (0,0) whenever eval_o is low. While eval_o is high, every pair is (1,0) or (0,1) and never (1,1).
- R4: done_o pulses for one clock once per 12-clock step, in the cycle after the capture edge. ct_t_o and ct_f_o change only on the edge that raises done_o.
- R5: When done_o is high, ct_t_o equals the AES S-box of (pt_o XOR k). Here k is the value key_i held on the last clock edge with eval_o low before that step's window.
- R6: Once the first result has been captured, ct_f_o is the bitwise complement of ct_t_o on every cycle.
- R7: The first pt_o after reset is the seed 0xA5. Each later step's pt_o follows from the previous one s as {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R8: A change of key_i while eval_o is high has no effect on the result captured at the end of that window.
- R9: The substitution gives the AES values at the edges of the input range: 0x00 to 0x63, 0x01 to 0x7C, 0x0F to 0x76, 0x10 to 0xCA, 0x53 to 0xED, 0x80 to 0xCD, 0xF0 to 0x8C and 0xFF to 0x16.
- R10: A reset applied mid-operation restarts the step sequence, so the next pt_o is the seed 0xA5 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | 8 | True-rail key byte, sampled while the evaluation window is closed |
| ct_t_o | output | 8 | True-rail substitution result register |
| ct_f_o | output | 8 | False-rail substitution result register |
| pt_o | output | 8 | Plaintext byte that produced the current result |
| done_o | output | 1 | One-clock pulse when a new result is in the registers |
| eval_o | output | 1 | Evaluation window open (both strobes high) |
| lead_o | output | 1 | Leading phase strobe |
| lag_o | output | 1 | Lagging phase strobe, one clock behind the leading one |

## Verification
The rail-pair assertions assume that the false-rail source values are built inside the block as the inverse of the true-rail values. They also assume that no external input reaches a gate directly. The key reaches the gates only through a register that loads while the window is closed. The bench therefore changes key_i only at falling clock edges. It moves key_i into the open window only on purpose, to show that the captured result ignores the change. The bench picks each key from its own model of the plaintext generator, so that the S-box input takes chosen boundary values.

// File: rtl/drp_pkg.sv
package drp_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;
  localparam logic [BYTE_W-1:0] FIELD_RED = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;

  // multiplication in GF(2^8) modulo x^8+x^4+x^3+x+1, shift-and-add form
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t aa;
    byte_t bb;
    acc = '0;
    aa  = a;
    bb  = b;
    for (int i = 0; i < BYTE_W; i++) begin
      if (bb[0]) acc = acc ^ aa;
      if (aa[BYTE_W-1]) aa = (aa << 1) ^ FIELD_RED;
      else              aa = aa << 1;
      bb = bb >> 1;
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (maps zero to zero)
  function automatic byte_t gf_inv(input byte_t x);
    byte_t res;
    byte_t base;
    logic [BYTE_W-1:0] expo;
    res  = 8'h01;
    base = x;
    expo = 8'hFE;
    for (int i = 0; i < BYTE_W; i++) begin
      if (expo[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic byte_t sub_affine(input byte_t v);
    byte_t o;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = v[i] ^ v[(i+4)%BYTE_W] ^ v[(i+5)%BYTE_W] ^
             v[(i+6)%BYTE_W] ^ v[(i+7)%BYTE_W] ^ AFFINE_C[i];
    end
    return o;
  endfunction

  function automatic byte_t sub_byte(input byte_t x);
    return sub_affine(gf_inv(x));
  endfunction

endpackage

// File: rtl/drp_phase_gen.sv
module drp_phase_gen #(
  parameter int JW       = 6,
  parameter int LEAD_BIT = 0
) (
  input  logic clk,
  input  logic rst,
  output logic lead,
  output logic lag,
  output logic eval,
  output logic cap
);

  localparam int LAG_BIT = LEAD_BIT + 1;

  logic [JW-1:0] jc_q;
  logic [JW-1:0] jc_nx;
  logic          eval_nx;

  // twisted-ring counter: 2*JW states per step
  assign jc_nx = {jc_q[JW-2:0], ~jc_q[JW-1]};

  always_ff @(posedge clk) begin
    if (rst) jc_q <= '0;
    else     jc_q <= jc_nx;
  end

  assign lead    = jc_q[LEAD_BIT];
  assign lag     = jc_q[LAG_BIT];
  assign eval    = lead & lag;
  assign eval_nx = jc_nx[LEAD_BIT] & jc_nx[LAG_BIT];
  // last cycle of the window: results are taken on this edge
  assign cap     = eval & ~eval_nx;

endmodule

// File: rtl/drp_lfsr.sv
module drp_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8,
  parameter logic [W-1:0]    SEED = 8'hA5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] st_q;
  logic         fb;

  assign fb = ^(st_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst)       st_q <= SEED;
    else if (step) st_q <= {st_q[W-2:0], fb};
  end

  assign state = st_q;

endmodule

// File: rtl/drp_xor_stage.sv
module drp_xor_stage #(
  parameter int W = 8
) (
  input  logic         eval,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] o_t,
  output logic [W-1:0] o_f
);

  // one dual-rail XOR cell per bit, both outputs held at zero outside the window
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign o_t[i] = eval & ((a_t[i] & b_f[i]) | (a_f[i] & b_t[i]));
    assign o_f[i] = eval & ((a_t[i] & b_t[i]) | (a_f[i] & b_f[i]));
  end

endmodule

// File: rtl/drp_sbox_half.sv
module drp_sbox_half
  import drp_pkg::*;
#(
  parameter bit FALSE_RAIL = 1'b0
) (
  input  logic  eval,
  input  byte_t x,
  output byte_t y
);

  if (FALSE_RAIL) begin : g_false
    // complement domain: input and output both carry inverted sense
    assign y = eval ? ~sub_byte(~x) : '0;
  end else begin : g_true
    assign y = eval ? sub_byte(x) : '0;
  end

endmodule

// File: rtl/drp_byte_core.sv
module drp_byte_core
  import drp_pkg::*;
#(
  parameter int          JW       = 6,
  parameter int          LEAD_BIT = 0,
  parameter logic [7:0]  SEED     = 8'hA5,
  parameter logic [7:0]  TAPS     = 8'hB8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] key_i,
  output logic [7:0] ct_t_o,
  output logic [7:0] ct_f_o,
  output logic [7:0] pt_o,
  output logic       done_o,
  output logic       eval_o,
  output logic       lead_o,
  output logic       lag_o
);

  localparam int NRAIL = 2;

  logic  lead, lag, eval, cap;
  byte_t lfsr_q;
  byte_t key_q;
  byte_t src_pt_t, src_pt_f, src_key_t, src_key_f;
  byte_t mix_t, mix_f;
  byte_t sb_t, sb_f;
  byte_t sb_rail [NRAIL];
  byte_t ct_t_q, ct_f_q, pt_q;
  logic  done_q, ct_vld;

  drp_phase_gen #(.JW(JW), .LEAD_BIT(LEAD_BIT)) u_phase (
    .clk (clk),
    .rst (rst),
    .lead(lead),
    .lag (lag),
    .eval(eval),
    .cap (cap)
  );

  drp_lfsr #(.W(BYTE_W), .TAPS(TAPS), .SEED(SEED)) u_prng (
    .clk  (clk),
    .rst  (rst),
    .step (cap),
    .state(lfsr_q)
  );

  // source registers released to the gates only inside the window
  assign src_pt_t  = eval ? lfsr_q : '0;
  assign src_pt_f  = eval ? ~lfsr_q : '0;
  assign src_key_t = eval ? key_q : '0;
  assign src_key_f = eval ? ~key_q : '0;

  drp_xor_stage #(.W(BYTE_W)) u_mix (
    .eval(eval),
    .a_t (src_pt_t),
    .a_f (src_pt_f),
    .b_t (src_key_t),
    .b_f (src_key_f),
    .o_t (mix_t),
    .o_f (mix_f)
  );

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    drp_sbox_half #(.FALSE_RAIL(r == 1)) u_sub (
      .eval(eval),
      .x   ((r == 0) ? mix_t : mix_f),
      .y   (sb_rail[r])
    );
  end

  assign sb_t = sb_rail[0];
  assign sb_f = sb_rail[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      ct_t_q <= '0;
      ct_f_q <= '0;
      pt_q   <= '0;
      done_q <= 1'b0;
      ct_vld <= 1'b0;
    end else begin
      done_q <= cap;
      if (!eval) key_q <= key_i;
      if (cap) begin
        ct_t_q <= sb_t;
        ct_f_q <= sb_f;
        pt_q   <= lfsr_q;
        ct_vld <= 1'b1;
      end
    end
  end

  assign ct_t_o = ct_t_q;
  assign ct_f_o = ct_f_q;
  assign pt_o   = pt_q;
  assign done_o = done_q;
  assign eval_o = eval;
  assign lead_o = lead;
  assign lag_o  = lag;

endmodule

// File: rtl/drp_byte_core_chk.sv
module drp_byte_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       lead,
  input logic       lag,
  input logic       eval,
  input logic [7:0] mix_t,
  input logic [7:0] mix_f,
  input logic [7:0] sb_t,
  input logic [7:0] sb_f,
  input logic [7:0] ct_t,
  input logic [7:0] ct_f,
  input logic [7:0] pt,
  input logic       done,
  input logic       ct_vld
);

  AST_LAG_FOLLOWS_LEAD: assert property (@(posedge clk) disable iff (rst)
    lag == $past(lead)); // R2

  AST_PRECHARGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !eval |-> (mix_t == 8'h00 && mix_f == 8'h00 && sb_t == 8'h00 && sb_f == 8'h00)); // R3

  AST_RAIL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    eval |-> ((mix_t ^ mix_f) == 8'hFF && (mix_t & mix_f) == 8'h00 &&
              (sb_t ^ sb_f) == 8'hFF && (sb_t & sb_f) == 8'h00)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ct_t) && $stable(ct_f))); // R4

  AST_RAILS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    ct_vld |-> (ct_f == ~ct_t)); // R6

  AST_PRNG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    ct_vld |-> (pt != 8'h00)); // R7

endmodule

bind drp_byte_core drp_byte_core_chk i_chk (
  .clk   (clk),
  .rst   (rst),
  .lead  (lead),
  .lag   (lag),
  .eval  (eval),
  .mix_t (mix_t),
  .mix_f (mix_f),
  .sb_t  (sb_t),
  .sb_f  (sb_f),
  .ct_t  (ct_t_q),
  .ct_f  (ct_f_q),
  .pt    (pt_q),
  .done  (done_q),
  .ct_vld(ct_vld)
);

// File: tb/test_drp_byte_core.sv
`timescale 1ns/1ps
module test_drp_byte_core;

  localparam logic [7:0] SEED = 8'hA5;
  localparam int NVEC = 8;
  localparam logic [7:0] VIN  [NVEC] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h53, 8'h80, 8'hF0, 8'hFF};
  localparam logic [7:0] VEXP [NVEC] = '{8'h63, 8'h7C, 8'h76, 8'hCA, 8'hED, 8'hCD, 8'h8C, 8'h16};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] key_i = 8'h00;
  logic [7:0] ct_t_o, ct_f_o, pt_o;
  logic       done_o, eval_o, lead_o, lag_o;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] mpt;

  always #5 clk = ~clk;

  drp_byte_core i_drp_byte_core (
    .clk   (clk),
    .rst   (rst),
    .key_i (key_i),
    .ct_t_o(ct_t_o),
    .ct_f_o(ct_f_o),
    .pt_o  (pt_o),
    .done_o(done_o),
    .eval_o(eval_o),
    .lead_o(lead_o),
    .lag_o (lag_o)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] a);
    if (a == 8'h00) return 8'h00;
    for (int b = 1; b < 256; b++) if (m_mul(a, 8'(b)) == 8'h01) return 8'(b);
    return 8'h00;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] v;
    v = m_inv(x);
    return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] m_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic check_result(input string tag, input logic [7:0] key);
    chk({tag, " R7 plaintext"}, pt_o, mpt);
    chk({tag, " R5 true rail"}, ct_t_o, m_sbox(mpt ^ key));
    chk({tag, " R6 false rail"}, ct_f_o, ~ct_t_o);
    mpt = m_step(mpt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] k;
    int n_lead, n_lag, n_eval, n_done, n_badlag, n_chg;
    logic prev_lead;
    logic [7:0] prev_ct;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ct_t", ct_t_o, 8'h00);
    chk("R1 ct_f", ct_f_o, 8'h00);
    chk("R1 pt", pt_o, 8'h00);
    chk("R1 done/eval", {6'd0, done_o, eval_o}, 8'h00);

    mpt = SEED;
    key_i = mpt ^ VIN[0];
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", {4'd0, done_o, eval_o, ct_t_o[0] | ct_f_o[0], pt_o[0]}, 8'h00);

    // R9: boundary S-box inputs chosen through the key
    for (int v = 0; v < NVEC; v++) begin
      key_i = mpt ^ VIN[v];
      wait_done();
      chk("R9 known value", ct_t_o, VEXP[v]);
      check_result("table", mpt ^ VIN[v]);
    end

    // R5 R6 R7: stepped key pattern
    k = 8'h3C;
    for (int n = 0; n < 16; n++) begin
      key_i = k;
      wait_done();
      check_result("sweep", k);
      k = k * 8'd37 + 8'd11;
    end

    // R8: key toggled inside the window is ignored
    key_i = 8'h5A;
    do @(negedge clk); while (!eval_o);
    key_i = 8'hA5;
    wait_done();
    key_i = 8'h5A;
    check_result("R8 key change in window", 8'h5A);

    // R2 R4: strobe shape and result timing over one step
    n_lead = 0; n_lag = 0; n_eval = 0; n_done = 0; n_badlag = 0; n_chg = 0;
    prev_lead = lead_o;
    prev_ct = ct_t_o;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      n_lead += int'(lead_o);
      n_lag  += int'(lag_o);
      n_eval += int'(eval_o);
      n_done += int'(done_o);
      if (lag_o !== prev_lead) n_badlag++;
      if (ct_t_o !== prev_ct && !done_o) n_chg++;
      if (eval_o !== (lead_o & lag_o)) n_badlag++;
      prev_lead = lead_o;
      prev_ct = ct_t_o;
    end
    chk("R2 lead high count", 8'(n_lead), 8'd6);
    chk("R2 lag high count", 8'(n_lag), 8'd6);
    chk("R2 eval high count", 8'(n_eval), 8'd5);
    chk("R2 lag delay mismatches", 8'(n_badlag), 8'd0);
    chk("R4 done pulses per step", 8'(n_done), 8'd1);
    chk("R4 result change without done", 8'(n_chg), 8'd0);
    mpt = m_step(mpt);

    // R10: reset in the middle of a step
    key_i = 8'hC3;
    do @(negedge clk); while (!eval_o);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ct_t after mid reset", ct_t_o, 8'h00);
    chk("R1 ct_f after mid reset", ct_f_o, 8'h00);
    chk("R1 done/eval after mid reset", {6'd0, done_o, eval_o}, 8'h00);
    rst = 1'b0;
    mpt = SEED;
    wait_done();
    chk("R10 restart seed", pt_o, SEED);
    check_result("R10 after reset", 8'hC3);
    wait_done();
    check_result("R10 second step", 8'hC3);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule